// File: doc/BRIEF.md
# IDE Channel Interrupt Router

This block takes the interrupt lines of two IDE channels and decides which host-side interrupt pins carry them. There are two legacy edge lines, IRQ14 and IRQ15, and two shared open-drain PCI lines, INTA# and INTB#. The choice depends on three things: the chip enable, a board strap that says whether a legacy interrupt header is fitted, and whether each channel decodes at its legacy I/O base. A per-channel mask can silence a channel on whichever pin it has been routed to. A pending bit for each channel follows the raw interrupt and ignores both the mask and the enable.

The drive interrupt lines come from off-chip and are asynchronous, so they pass through a synchronizer of configurable depth first. All pin values, pin output enables and pending bits are registered, so the pins never glitch while configuration inputs change. The register file that holds the mask, decode-enable and base-address fields is outside this block, and so are the pad drivers. Each tri-state pin is presented as a value and an output enable. The open-drain lines are presented as an output enable only, and the pad drives low while that enable is set.

Top module: `ide_irq_router`

## Requirements
- R1: With `chip_en_i` low, all four pin output enables (`irq14_oe_o`, `irq15_oe_o`, `inta_oe_o`, `intb_oe_o`) are 0 and `irq14_o`/`irq15_o` are 0.
- R2: With the chip enabled and `header_i` low, both legacy pins are off. `inta_oe_o` is 1 exactly when channel 0 interrupts and `ch_mask_i[0]` is 0. `intb_oe_o` is 1 exactly when channel 1 interrupts and `ch_mask_i[1]` is 0.
- R3: With the chip enabled, `header_i` high and channel 0 at its legacy base, IRQ14 is driven (`irq14_oe_o`=1) with `irq14_o` equal to the channel 0 interrupt when `ch_mask_i[0]` is 0. When that mask is 1, IRQ14 is tri-stated and `irq14_o` is 0.
- R4: With the chip enabled, `header_i` high and channel 1 at its legacy base, IRQ15 follows channel 1 in the same way under `ch_mask_i[1]`. In every case where a channel is not at its legacy base, or the header is absent, the matching legacy pin is tri-stated.
- R5: With the chip enabled, `header_i` high and neither channel at its legacy base, `inta_oe_o` is 1 exactly when at least one channel interrupts and neither mask bit is set.
- R6: With the chip enabled, `header_i` high and exactly one channel away from its legacy base, `inta_oe_o` is 1 exactly when that channel interrupts and is unmasked. The channel at its legacy base has no effect on INTA#. With both channels at their legacy bases, INTA# stays off.
- R7: With `header_i` high, `intb_oe_o` is always 0.
- R8: Channel 0 is at its legacy base only when `ch_dec_en_i[0]` is 1 and `ch0_base_i` equals `PRI_BASE` (default 16'h01F0). Channel 1 is at its legacy base only when `ch_dec_en_i[1]` is 1 and `ch1_base_i` equals `SEC_BASE` (default 16'h0170). Any other base, including one differing in a single bit, counts as a non-legacy port.
- R9: `pend_o[n]` is 1 exactly when channel n's synchronized interrupt is asserted, regardless of the mask, the strap and the chip enable.
- R10: A change on `chip_en_i`, `header_i`, base, decode-enable or mask inputs reaches the outputs at the first rising clock edge. A change on `ch_irq_i` reaches the outputs and the pending bits at rising edge SYNC_STAGES+1 (edge 3 by default) and not earlier.
- R11: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Chip enable from configuration |
| header_i | input | 1 | Legacy interrupt header strap, 1 = fitted |
| ch0_base_i | input | BASE_W | Channel 0 data-port base address |
| ch1_base_i | input | BASE_W | Channel 1 data-port base address |
| ch_dec_en_i | input | 2 | Per-channel I/O decode enable |
| ch_mask_i | input | 2 | Per-channel interrupt mask, 1 = masked |
| ch_irq_i | input | 2 | Asynchronous drive interrupt per channel |
| irq14_o | output | 1 | IRQ14 value |
| irq14_oe_o | output | 1 | IRQ14 output enable |
| irq15_o | output | 1 | IRQ15 value |
| irq15_oe_o | output | 1 | IRQ15 output enable |
| inta_oe_o | output | 1 | INTA# pull-low enable |
| intb_oe_o | output | 1 | INTB# pull-low enable |
| pend_o | output | 2 | Per-channel pending status |

## Verification
Configuration inputs reach the outputs one edge after they change. The drive interrupt lines reach the outputs only after SYNC_STAGES+1 edges, because they pass through the synchronizer and then the output register. The bench drives every stimulus on a falling edge and holds it. It waits out the longer of the two latencies and samples on the next falling edge, so each check compares settled results against its reference function. A dedicated latency test raises one interrupt and samples on the falling edge after each rising edge. It confirms the pin stays quiet through edge SYNC_STAGES and rises at edge SYNC_STAGES+1, and that clearing the chip enable takes effect after a single edge.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic irq14;
    logic irq14_oe;
    logic irq15;
    logic irq15_oe;
    logic inta_oe;
    logic intb_oe;
  } pin_route_t;
endpackage

// File: rtl/ide_irq_sync.sv
module ide_irq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stage_q <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ide_irq_legacy_match.sv
module ide_irq_legacy_match #(
  parameter int                          NUM_CH  = 2,
  parameter int                          BASE_W  = 16,
  parameter logic [NUM_CH*BASE_W-1:0]    LEGACY  = '0
) (
  input  logic [NUM_CH*BASE_W-1:0] base_i,
  input  logic [NUM_CH-1:0]        dec_en_i,
  output logic [NUM_CH-1:0]        at_legacy_o
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign at_legacy_o[c] = dec_en_i[c] &&
        (base_i[c*BASE_W +: BASE_W] == LEGACY[c*BASE_W +: BASE_W]);
    end
  endgenerate
endmodule

// File: rtl/ide_irq_route.sv
module ide_irq_route
  import ide_irq_pkg::*;
(
  input  logic       chip_en_i,
  input  logic       header_i,
  input  logic [1:0] at_legacy_i,
  input  logic [1:0] mask_i,
  input  logic [1:0] irq_i,
  output pin_route_t route_o
);
  logic [1:0] live;
  assign live = irq_i & ~mask_i;

  always_comb begin
    route_o = '0;
    if (chip_en_i) begin
      if (!header_i) begin
        route_o.inta_oe = live[0];
        route_o.intb_oe = live[1];
      end else begin
        route_o.irq14_oe = at_legacy_i[0] & ~mask_i[0];
        route_o.irq14    = at_legacy_i[0] & live[0];
        route_o.irq15_oe = at_legacy_i[1] & ~mask_i[1];
        route_o.irq15    = at_legacy_i[1] & live[1];
        unique case (at_legacy_i)
          2'b00:   route_o.inta_oe = (irq_i[0] | irq_i[1]) & ~mask_i[0] & ~mask_i[1];
          2'b10:   route_o.inta_oe = live[0];
          2'b01:   route_o.inta_oe = live[1];
          default: route_o.inta_oe = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ide_irq_router.sv
module ide_irq_router
  import ide_irq_pkg::*;
#(
  parameter int               BASE_W      = 16,
  parameter logic [BASE_W-1:0] PRI_BASE   = 16'h01F0,
  parameter logic [BASE_W-1:0] SEC_BASE   = 16'h0170,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic              header_i,
  input  logic [BASE_W-1:0] ch0_base_i,
  input  logic [BASE_W-1:0] ch1_base_i,
  input  logic [1:0]        ch_dec_en_i,
  input  logic [1:0]        ch_mask_i,
  input  logic [1:0]        ch_irq_i,
  output logic              irq14_o,
  output logic              irq14_oe_o,
  output logic              irq15_o,
  output logic              irq15_oe_o,
  output logic              inta_oe_o,
  output logic              intb_oe_o,
  output logic [1:0]        pend_o
);
  localparam logic [NUM_CH*BASE_W-1:0] LEGACY_MAP = {SEC_BASE, PRI_BASE};

  logic [NUM_CH-1:0] irq_s;
  logic [NUM_CH-1:0] at_legacy;
  pin_route_t        route_d, route_q;
  logic [NUM_CH-1:0] pend_q;

  ide_irq_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ch_irq_i),
    .q_o    (irq_s)
  );

  ide_irq_legacy_match #(.NUM_CH(NUM_CH), .BASE_W(BASE_W), .LEGACY(LEGACY_MAP)) u_match (
    .base_i      ({ch1_base_i, ch0_base_i}),
    .dec_en_i    (ch_dec_en_i),
    .at_legacy_o (at_legacy)
  );

  ide_irq_route u_route (
    .chip_en_i   (chip_en_i),
    .header_i    (header_i),
    .at_legacy_i (at_legacy),
    .mask_i      (ch_mask_i),
    .irq_i       (irq_s),
    .route_o     (route_d)
  );

  // registered pins: no glitch while config fields move
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      pend_q  <= '0;
    end else begin
      route_q <= route_d;
      pend_q  <= irq_s;
    end
  end

  assign irq14_o    = route_q.irq14;
  assign irq14_oe_o = route_q.irq14_oe;
  assign irq15_o    = route_q.irq15;
  assign irq15_oe_o = route_q.irq15_oe;
  assign inta_oe_o  = route_q.inta_oe;
  assign intb_oe_o  = route_q.intb_oe;
  assign pend_o     = pend_q;
endmodule

// File: rtl/ide_irq_router_chk.sv
module ide_irq_router_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chip_en_i,
  input logic       header_i,
  input logic [1:0] ch_mask_i,
  input logic       irq14_o,
  input logic       irq14_oe_o,
  input logic       irq15_o,
  input logic       irq15_oe_o,
  input logic       inta_oe_o,
  input logic       intb_oe_o
);
  // R1
  disabled_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!chip_en_i) |-> !(irq14_oe_o || irq15_oe_o || inta_oe_o || intb_oe_o || irq14_o || irq15_o));

  // R2
  no_header_legacy_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!header_i) |-> !irq14_oe_o && !irq15_oe_o);

  // R2
  no_header_mask0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!header_i && ch_mask_i[0]) |-> !inta_oe_o);

  // R2
  no_header_mask1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!header_i && ch_mask_i[1]) |-> !intb_oe_o);

  // R7
  header_intb_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(header_i) |-> !intb_oe_o);

  // R3
  irq14_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ch_mask_i[0]) |-> !irq14_oe_o && !irq14_o);

  // R4
  irq15_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ch_mask_i[1]) |-> !irq15_oe_o && !irq15_o);
endmodule

bind ide_irq_router ide_irq_router_chk u_chk (.*);

// File: tb/ide_irq_router_bench.sv
module ide_irq_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam logic [15:0] PRI = 16'h01F0;
  localparam logic [15:0] SEC = 16'h0170;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, header = 1'b0;
  logic [15:0] b0 = '0, b1 = '0;
  logic [1:0] dec_en = '0, mask = '0, irq = '0;
  logic irq14, irq14_oe, irq15, irq15_oe, inta_oe, intb_oe;
  logic [1:0] pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_irq_router #(.SYNC_STAGES(SYNC)) u_ide_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(chip_en), .header_i(header),
    .ch0_base_i(b0), .ch1_base_i(b1), .ch_dec_en_i(dec_en), .ch_mask_i(mask),
    .ch_irq_i(irq), .irq14_o(irq14), .irq14_oe_o(irq14_oe), .irq15_o(irq15),
    .irq15_oe_o(irq15_oe), .inta_oe_o(inta_oe), .intb_oe_o(intb_oe), .pend_o(pend)
  );

  // {irq14, irq14_oe, irq15, irq15_oe, inta_oe, intb_oe, pend[1], pend[0]}
  function automatic logic [7:0] expect_pins();
    logic l0, l1, a, bb;
    logic [7:0] r;
    l0 = dec_en[0] && (b0 == PRI);
    l1 = dec_en[1] && (b1 == SEC);
    r = {6'b0, irq};
    if (chip_en) begin
      if (!header) begin
        r[3] = irq[0] && !mask[0];
        r[2] = irq[1] && !mask[1];
      end else begin
        r[6] = l0 && !mask[0];
        r[7] = l0 && !mask[0] && irq[0];
        r[4] = l1 && !mask[1];
        r[5] = l1 && !mask[1] && irq[1];
        a = irq[0] && !mask[0];
        bb = irq[1] && !mask[1];
        if (!l0 && !l1)     r[3] = (irq[0] || irq[1]) && !mask[0] && !mask[1];
        else if (!l0)       r[3] = a;
        else if (!l1)       r[3] = bb;
      end
    end
    return r;
  endfunction

  function automatic string tag_of();
    if (!chip_en) return "R1";
    if (!header) return "R2";
    if (!(dec_en[0] && b0 == PRI) && !(dec_en[1] && b1 == SEC)) return "R5";
    if (!(dec_en[0] && b0 == PRI) || !(dec_en[1] && b1 == SEC)) return "R6";
    return "R3";
  endfunction

  function automatic logic [7:0] actual();
    return {irq14, irq14_oe, irq15, irq15_oe, inta_oe, intb_oe, pend};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // inputs already set on a falling edge; wait out full irq latency
  task automatic settle_check(string tag);
    repeat (SYNC + 1) @(posedge clk);
    @(negedge clk);
    check(tag, actual(), expect_pins());
  endtask

  task automatic drive(logic en, logic hd, logic [15:0] x0, logic [15:0] x1,
                       logic [1:0] de, logic [1:0] mk, logic [1:0] iq);
    chip_en = en; header = hd; b0 = x0; b1 = x1; dec_en = de; mask = mk; irq = iq;
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] rb0, rb1;
    void'($urandom(32'h1DE5EED));
    drive(1'b1, 1'b1, PRI, SEC, 2'b11, 2'b00, 2'b11);
    repeat (3) @(negedge clk);
    // R11 reset state with active-looking inputs
    check("R11", actual(), 8'h00);
    rst_n = 1'b1;

    // R1 disabled
    drive(1'b0, 1'b1, PRI, SEC, 2'b11, 2'b00, 2'b11); settle_check("R1");
    drive(1'b0, 1'b0, 16'h1234, 16'h0, 2'b00, 2'b00, 2'b11); settle_check("R1");
    // R2 header absent, mask combos
    drive(1'b1, 1'b0, PRI, SEC, 2'b11, 2'b00, 2'b11); settle_check("R2");
    drive(1'b1, 1'b0, PRI, SEC, 2'b11, 2'b01, 2'b11); settle_check("R2");
    drive(1'b1, 1'b0, PRI, SEC, 2'b11, 2'b10, 2'b01); settle_check("R2");
    // R3 / R4 legacy pins
    drive(1'b1, 1'b1, PRI, SEC, 2'b11, 2'b00, 2'b01); settle_check("R3");
    drive(1'b1, 1'b1, PRI, SEC, 2'b11, 2'b01, 2'b11); settle_check("R3");
    drive(1'b1, 1'b1, PRI, SEC, 2'b11, 2'b00, 2'b10); settle_check("R4");
    drive(1'b1, 1'b1, PRI, SEC, 2'b11, 2'b10, 2'b00); settle_check("R4");
    // R5 shared INTA
    drive(1'b1, 1'b1, 16'h0400, 16'h0500, 2'b11, 2'b00, 2'b10); settle_check("R5");
    drive(1'b1, 1'b1, 16'h0400, 16'h0500, 2'b11, 2'b01, 2'b10); settle_check("R5");
    drive(1'b1, 1'b1, 16'h0400, 16'h0500, 2'b11, 2'b00, 2'b00); settle_check("R5");
    // R6 one channel on INTA, other on its legacy pin
    drive(1'b1, 1'b1, 16'h0400, SEC, 2'b11, 2'b00, 2'b10); settle_check("R6");
    drive(1'b1, 1'b1, 16'h0400, SEC, 2'b11, 2'b00, 2'b01); settle_check("R6");
    drive(1'b1, 1'b1, PRI, 16'h0500, 2'b11, 2'b00, 2'b11); settle_check("R6");
    drive(1'b1, 1'b1, PRI, SEC, 2'b11, 2'b00, 2'b11); settle_check("R6");
    // R7 INTB never with header
    drive(1'b1, 1'b1, 16'h0400, 16'h0500, 2'b11, 2'b00, 2'b11); settle_check("R7");
    // R8 legacy match rule
    drive(1'b1, 1'b1, PRI, SEC, 2'b00, 2'b00, 2'b01); settle_check("R8");
    drive(1'b1, 1'b1, PRI ^ 16'h0001, SEC, 2'b11, 2'b00, 2'b01); settle_check("R8");
    drive(1'b1, 1'b1, SEC, PRI, 2'b11, 2'b00, 2'b10); settle_check("R8");
    // R9 pending ignores mask and enable
    drive(1'b0, 1'b1, PRI, SEC, 2'b11, 2'b11, 2'b11); settle_check("R9");
    check("R9", {6'b0, pend}, 8'h03);

    // R10 irq latency
    drive(1'b1, 1'b0, PRI, SEC, 2'b11, 2'b00, 2'b00); settle_check("R10");
    irq = 2'b01;
    for (int k = 1; k <= SYNC + 1; k++) begin
      @(posedge clk); @(negedge clk);
      check("R10", {6'b0, inta_oe, pend[0]}, (k == SYNC + 1) ? 8'h03 : 8'h00);
    end
    // R10 config latency
    chip_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10", {7'b0, inta_oe}, 8'h00);

    // random mix
    for (int n = 0; n < 400; n++) begin
      rb0 = ($urandom_range(0, 2) == 0) ? 16'($urandom) : PRI;
      rb1 = ($urandom_range(0, 2) == 0) ? 16'($urandom) : SEC;
      drive(($urandom_range(0, 5) != 0), 1'($urandom), rb0, rb1,
            2'($urandom) | 2'($urandom), 2'($urandom & $urandom), 2'($urandom));
      settle_check(tag_of());
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule